// File: doc/BRIEF.md
# Burst Column Address Generator

This block generates the column address stream for one read or write burst of a synchronous DRAM. A memory controller or a memory behavioural model presents a length code and an order bit, then pulses a start input together with the starting column and the bank. Starting on the clock after that pulse, the block puts out one column address per cycle. Each address comes with a valid flag, and a last flag marks the final beat of a finite burst.

Two wrap orders are supported. In sequential order the low bits of the column count upward and wrap within an aligned window. In interleave order the start column is XORed with the beat number. A full-page setting walks every column, wraps from the top column back to zero and runs until it is stopped. A terminate input stops any burst on any cycle. A fresh start can replace a running burst on any cycle, with no alignment restriction. The block stays out of latency alignment, data movement, refresh and row activation.

Top module: `burst_colgen`

## Requirements
- R1: The length code `cfg_len` selects the burst length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. A legal start sampled at a rising edge makes `out_valid` high for exactly that many cycles, beginning in the cycle right after that edge. `out_last` is high only on the final beat.
- R2: With `cfg_ilv`=0 (sequential) and length N, beat j carries the column whose upper bits come from the start column. Its low log2(N) bits equal (start low bits + j) mod N.
- R3: With `cfg_ilv`=1 (interleave) and length N, beat j carries the start column XOR j.
- R4: Code 7 with `cfg_ilv`=0 selects full page. Beat j carries (start + j) mod 512, so column 511 is followed by column 0. The burst keeps going past 512 beats, and `out_last` is never raised.
- R5: Codes 4, 5 and 6, and code 7 with `cfg_ilv`=1, are illegal. For those, `mode_bad` is high in the same cycle, decoded directly from `cfg_len` and `cfg_ilv`, and a start pulse emits no beats. For legal settings, `mode_bad` is low.
- R6: When `term` is high at an edge while a burst is showing a beat and no start is present, that beat is the last one emitted. `out_valid` is low in the next cycle.
- R7: A legal start during a running burst replaces it. The next cycle shows beat 0 of the new burst. A start wins over a `term` in the same cycle.
- R8: The bank given in `start_bank` appears on `out_bank` unchanged for every beat of the burst it started.
- R9: During and after reset, `out_valid` and `out_last` are low until a start arrives.
- R10: A start given in the cycle of a final beat continues with no idle cycle. When no start is given there, `out_valid` is low in the cycle after the final beat.
- R11: The length, order, column and bank are captured at the start. Changing `cfg_len` or `cfg_ilv` during a burst does not alter its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | Wrap order: 0 sequential, 1 interleave |
| start | input | 1 | Begin a burst with the current settings |
| start_col | input | 9 | Starting column |
| start_bank | input | 2 | Bank for the burst |
| term | input | 1 | Stop the burst in progress |
| out_valid | output | 1 | A beat address is present |
| out_last | output | 1 | Final beat of a finite burst |
| out_col | output | 9 | Column address of the current beat |
| out_bank | output | 2 | Bank of the current beat |
| mode_bad | output | 1 | Current length and order setting is illegal |

## Verification
The bench aims at start columns that sit in the middle of the wrap window, where a design that carried into the upper column bits would leave the aligned window instead of wrapping inside it. It runs a full-page burst across column 511 and beyond 512 beats: a wrong design would either stop at the page end or raise a last flag. It cuts bursts with terminate, interrupts them with new starts, and issues a start together with a terminate and a start on a final beat. A design that lets terminate win, leaves a bubble, or keeps the old bank would show a missing beat or an idle cycle. It also offers every illegal code and changes the settings in mid-burst. A design that decoded the settings on every cycle would either emit beats for an illegal code or change order halfway through a burst.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } wrap_order_t;

  localparam int unsigned DEF_COL_W   = 9;
  localparam int unsigned DEF_BANK_W  = 2;
  localparam int unsigned DEF_CODE_W  = 3;
  localparam int unsigned DEF_MAX_POW = 3;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W     = DEF_COL_W,
  parameter int unsigned CODE_W    = DEF_CODE_W,
  parameter int unsigned MAX_POW   = DEF_MAX_POW,
  parameter logic [CODE_W-1:0] FULL_CODE = '1
) (
  input  logic [CODE_W-1:0] code,
  input  wrap_order_t       order,
  output logic              legal,
  output logic              full,
  output logic [COL_W-1:0]  mask
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_POW);

  function automatic logic [COL_W-1:0] len_mask(input logic [CODE_W-1:0] c,
                                                input logic fp);
    logic [COL_W-1:0] m;
    for (int i = 0; i < int'(COL_W); i++) begin
      m[i] = fp || (i < int'(c));
    end
    return m;
  endfunction

  always_comb begin
    full  = (code == FULL_CODE);
    legal = (code <= MAX_CODE) || (full && order == ORD_SEQ);
    mask  = len_mask(code, full);
  end
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W  = DEF_COL_W,
  parameter int unsigned BANK_W = DEF_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              term,
  input  logic [COL_W-1:0]  ld_base,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [COL_W-1:0]  ld_mask,
  input  wrap_order_t       ld_order,
  input  logic              ld_full,
  output logic              active,
  output logic [COL_W-1:0]  cnt,
  output logic [COL_W-1:0]  base,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  mask,
  output wrap_order_t       order,
  output logic              full,
  output logic              at_end,
  output logic              stop
);
  always_comb begin
    at_end = active && !full && (cnt == mask);
    stop   = active && !load && (term || at_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      base   <= '0;
      bank   <= '0;
      mask   <= '0;
      order  <= ORD_SEQ;
      full   <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      base   <= ld_base;
      bank   <= ld_bank;
      mask   <= ld_mask;
      order  <= ld_order;
      full   <= ld_full;
    end else if (stop) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = DEF_COL_W
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  wrap_order_t      order,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] n,
                                               input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = b + n;
    return (b & ~m) | (sum & m);
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] n,
                                               input logic [COL_W-1:0] m);
    return b ^ (n & m);
  endfunction

  always_comb begin
    if (order == ORD_ILV) col = ilv_col(base, cnt, mask);
    else                  col = seq_col(base, cnt, mask);
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W   = DEF_COL_W,
  parameter int unsigned BANK_W  = DEF_BANK_W,
  parameter int unsigned CODE_W  = DEF_CODE_W,
  parameter int unsigned MAX_POW = DEF_MAX_POW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_len,
  input  logic              cfg_ilv,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              term,
  output logic              out_valid,
  output logic              out_last,
  output logic [COL_W-1:0]  out_col,
  output logic [BANK_W-1:0] out_bank,
  output logic              mode_bad
);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;

  wrap_order_t      cfg_order;
  logic             dec_legal;
  logic             dec_full;
  logic [COL_W-1:0] dec_mask;

  logic             ev_load;
  logic             ev_drop;
  logic             ev_end;
  logic             ev_stop;

  logic             burst_active;
  logic [COL_W-1:0] burst_cnt;
  logic [COL_W-1:0] burst_base;
  logic [COL_W-1:0] burst_mask;
  wrap_order_t      burst_order;
  logic             burst_full;

  assign cfg_order = wrap_order_t'(cfg_ilv);

  burst_mode_dec #(
    .COL_W(COL_W), .CODE_W(CODE_W), .MAX_POW(MAX_POW), .FULL_CODE(FULL_CODE)
  ) u_dec (
    .code  (cfg_len),
    .order (cfg_order),
    .legal (dec_legal),
    .full  (dec_full),
    .mask  (dec_mask)
  );

  assign ev_load = start && dec_legal;
  assign ev_drop = start && !dec_legal;

  burst_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .term     (term),
    .ld_base  (start_col),
    .ld_bank  (start_bank),
    .ld_mask  (dec_mask),
    .ld_order (cfg_order),
    .ld_full  (dec_full),
    .active   (burst_active),
    .cnt      (burst_cnt),
    .base     (burst_base),
    .bank     (out_bank),
    .mask     (burst_mask),
    .order    (burst_order),
    .full     (burst_full),
    .at_end   (ev_end),
    .stop     (ev_stop)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base  (burst_base),
    .cnt   (burst_cnt),
    .mask  (burst_mask),
    .order (burst_order),
    .col   (out_col)
  );

  assign out_valid = burst_active;
  assign out_last  = ev_end;
  assign mode_bad  = !dec_legal;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              term,
  input logic              mode_bad,
  input logic              out_valid,
  input logic              out_last,
  input logic [COL_W-1:0]  out_col,
  input logic [BANK_W-1:0] out_bank,
  input logic [COL_W-1:0]  start_col,
  input logic [BANK_W-1:0] start_bank,
  input logic              burst_full,
  input logic              ev_drop
);
  a_r1_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r4_full_never_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && burst_full) |-> !out_last);

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !start) |=> !out_valid);

  a_r6_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && term && !start) |=> !out_valid);

  a_r7_start_gives_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode_bad) |=> (out_valid && out_col == $past(start_col)
                              && out_bank == $past(start_bank)));

  a_r5_bad_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !out_valid) |=> !out_valid);

  a_r8_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !start && !term && !out_last) |=> (out_valid && $stable(out_bank)));
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .term       (term),
  .mode_bad   (mode_bad),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_col    (out_col),
  .out_bank   (out_bank),
  .start_col  (start_col),
  .start_bank (start_bank),
  .burst_full (burst_full),
  .ev_drop    (ev_drop)
);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_len = 3'd0;
  logic       cfg_ilv = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [1:0] start_bank = '0;
  logic       term = 1'b0;
  logic       out_valid, out_last, mode_bad;
  logic [8:0] out_col;
  logic [1:0] out_bank;

  always #5 clk = ~clk;

  burst_colgen u_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .start(start), .start_col(start_col), .start_bank(start_bank), .term(term),
    .out_valid(out_valid), .out_last(out_last), .out_col(out_col),
    .out_bank(out_bank), .mode_bad(mode_bad)
  );

  int checks = 0;
  int errors = 0;
  logic [11:0] expq[$];
  string       tagq[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_legal(input int code, input bit ilv);
    return (code <= 3) || (code == 7 && !ilv);
  endfunction

  function automatic int beats_of(input int code);
    return (code == 7) ? 512 : (1 << code);
  endfunction

  function automatic logic [8:0] model_col(input int code, input bit ilv,
                                           input int col, input int j);
    int n;
    if (code == 7) return 9'((col + j) % 512);
    n = 1 << code;
    if (ilv) return 9'(col ^ j);
    return 9'((col / n) * n + ((col % n) + j) % n);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Drive a start now, queue the first `keep` beats it should produce.
  task automatic issue(input int code, input bit ilv, input int col,
                       input int bank, input int keep, input string tag);
    int n;
    cfg_len = 3'(code); cfg_ilv = ilv;
    start_col = 9'(col); start_bank = 2'(bank);
    start = 1'b1;
    if (is_legal(code, ilv)) begin
      n = beats_of(code);
      for (int j = 0; j < keep; j++) begin
        if (code != 7 && j >= n) break;
        expq.push_back({model_col(code, ilv, col, j), 2'(bank),
                        (code != 7) && (j == n - 1)});
        tagq.push_back(tag);
      end
    end
    step();
    start = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 700 && expq.size() != 0; k++) step();
  endtask

  task automatic check_idle(input string tag);
    check(out_valid == 1'b0, tag, "valid low when idle", out_valid, 0);
    check(expq.size() == 0, tag, "all expected beats seen", expq.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R1", "unexpected beat col", out_col, -1);
      end else begin
        logic [11:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(out_col == e[11:3], t, "col", out_col, e[11:3]);
        check(out_bank == e[2:1], t, "bank", out_bank, e[2:1]);
        check(out_last == e[0], t, "last", out_last, e[0]);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      check(1'b0, "R1", "watchdog expired", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R9: outputs quiet in reset and just after
    check(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
    check(out_last == 1'b0, "R9", "last in reset", out_last, 0);
    rst_n = 1'b1;
    step();
    check_idle("R9");

    // R1 R2: sequential lengths from a mid-window column
    for (int c = 0; c <= 3; c++) begin
      issue(c, 1'b0, 9'h0AD, c, 8, "R2");
      drain(); step();
      check_idle("R1");
    end

    // R3: interleave lengths
    for (int c = 1; c <= 3; c++) begin
      issue(c, 1'b1, 9'h1F3, 3 - c, 8, "R3");
      drain(); step();
      check_idle("R3");
    end

    // R5: mode_bad decode and ignored starts
    for (int c = 0; c <= 7; c++) begin
      for (int o = 0; o <= 1; o++) begin
        cfg_len = 3'(c); cfg_ilv = o[0];
        #1;
        check(mode_bad == !is_legal(c, o[0]), "R5", "mode_bad", mode_bad,
              !is_legal(c, o[0]));
      end
    end
    issue(5, 1'b0, 9'h010, 1, 8, "R5"); step();
    check_idle("R5");
    issue(7, 1'b1, 9'h010, 1, 8, "R5"); step();
    check_idle("R5");

    // R4: full page across the page top, then terminate after 20 beats
    issue(7, 1'b0, 505, 2, 20, "R4");
    repeat (19) step();
    term = 1'b1; step(); term = 1'b0;
    check_idle("R4");
    // R4: beyond 512 beats it keeps going
    issue(7, 1'b0, 0, 1, 515, "R4");
    repeat (514) step();
    term = 1'b1; step(); term = 1'b0;
    check_idle("R4");

    // R6: terminate a length-8 burst after 3 beats
    issue(3, 1'b0, 9'h044, 0, 3, "R6");
    repeat (2) step();
    term = 1'b1; step(); term = 1'b0;
    check_idle("R6");

    // R7 R8: interrupt after 5 beats with a new bank and order
    issue(3, 1'b0, 9'h100, 0, 5, "R7");
    repeat (4) step();
    issue(2, 1'b1, 9'h0C6, 3, 4, "R8");
    drain(); step();
    check_idle("R7");

    // R7: start together with term, start wins
    issue(3, 1'b1, 9'h020, 1, 2, "R7");
    step();
    term = 1'b1;
    issue(1, 1'b0, 9'h155, 2, 2, "R7");
    term = 1'b0;
    drain(); step();
    check_idle("R7");

    // R10: new start on the final beat, no bubble
    issue(2, 1'b0, 9'h00E, 1, 4, "R10");
    repeat (3) step();
    issue(1, 1'b1, 9'h0F1, 2, 2, "R10");
    drain(); step();
    check_idle("R10");

    // R11: settings changed during a burst
    issue(3, 1'b0, 9'h0A3, 3, 8, "R11");
    cfg_len = 3'd0; cfg_ilv = 1'b1; start_bank = 2'd0; start_col = 9'h000;
    drain(); step();
    check_idle("R11");

    repeat (3) step();
    check_idle("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule